// File: doc/BRIEF.md
# Microcontroller Interrupt Request Controller

This block sits between a small CPU core and its interrupt-raising peripherals. It keeps one flag register bit per event, sets that bit when a peripheral reports a rollover, a completed transfer or a capture, and lets software read, set and clear the flags and the enable bits through an 8-bit register port. The flags are gated by per-source enables and, for the two counter-array groups, by a per-flag mask as well. A single winning request is then presented to the core as a registered valid bit with a 3-bit source index.

When the core vectors to a service routine it returns a one-cycle acknowledge that carries the serviced index. Only the two basic timer overflow flags are cleared by that acknowledge. Every other flag stays set until software clears it, because the handler has to find out which of several OR-ed events caused the request.

Top module: `intr_req_ctrl`

## Requirements
- R1: After a synchronous reset, every enable, mask and flag bit reads 0, `reg_rdata` is 0 and `irq_valid` is 0.
- R2: Register map, selected by `reg_addr`. 0 holds the enables: bit0 timer 0, bit1 timer 1, bit2 timer 2, bit3 counter group 0, bit4 serial, bit7 global. 1 holds bit0, the counter group 1 enable. 2 holds the flags: bit0 timer 0 overflow, bit1 timer 1 overflow, bit2 timer 2 overflow, bit3 timer 2 external, bit4 serial receive, bit5 serial transmit. 3 and 4 hold the flags of counter groups 0 and 1: bits [NMOD-1:0] module events, bit7 counter overflow. 5 and 6 hold the matching per-flag masks in the same bit positions. Address 7 and any undefined bit read 0. A write takes effect at the next clock edge. `reg_rdata` shows, one cycle later, the addressed register as it was before that edge.
- R3: A timer 0 or timer 1 event sets its flag. An acknowledge with index 0 clears the timer 0 flag, and an acknowledge with index 1 clears the timer 1 flag.
- R4: A peripheral event wins over a clear in the same cycle, whether the clear comes from an acknowledge or from a register write. A register write to a flag register wins over an acknowledge clear in the same cycle.
- R5: The timer 2 request is the OR of its overflow and external flags. An acknowledge leaves both flags unchanged.
- R6: A counter-group request is the OR of its flags, each ANDed with its own mask bit. A flag whose mask bit is 0 cannot raise a request.
- R7: The two counter-group enables live in different registers (address 0 bit3 and address 1 bit0). Counter-group flags are never cleared by an acknowledge.
- R8: The serial request is the OR of the receive and transmit flags. An acknowledge leaves both flags unchanged.
- R9: Each source raises a request only while its own enable bit is 1. When the global bit is 0, all requests are masked.
- R10: Among the active requests the lowest index wins. The indices are timer 0 = 0, timer 1 = 1, timer 2 = 2, counter group 0 = 3, counter group 1 = 4 and serial = 5.
- R11: `irq_valid` and `irq_idx` are registered. They reflect the flag and enable state one clock after that state is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t0_ovf_evt | input | 1 | Timer 0 rollover pulse |
| t1_ovf_evt | input | 1 | Timer 1 rollover pulse |
| t2_ovf_evt | input | 1 | Timer 2 overflow pulse |
| t2_ext_evt | input | 1 | Timer 2 external event pulse |
| ca_mod_evt | input | 2*NMOD | Counter-array module event pulses, group g at bits [g*NMOD +: NMOD] |
| ca_ovf_evt | input | 2 | Counter-array overflow pulse per group |
| rx_done_evt | input | 1 | Serial receive complete pulse |
| tx_done_evt | input | 1 | Serial transmit complete pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| ack_valid | input | 1 | Vector acknowledge from the core, one cycle |
| ack_idx | input | 3 | Source index being serviced |
| irq_valid | output | 1 | A request is pending |
| irq_idx | output | 3 | Index of the winning source |

## Verification
The bench builds the block with NMOD = 4 rather than the default of 5. Bits 4 to 6 of the counter-group registers are then undefined, so the masking of undefined bits on write and readback is exercised, and the overflow flag at bit 7 is kept apart from the module flags. Counter-group event vectors of each width are checked against a model that recomputes both the request gating and the readback on every clock. Directed phases are followed by a long random phase, in which writes, events and acknowledges of every index collide in the same cycle.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int SRC_N  = 6;
  localparam int IDX_W  = 3;
  localparam int DW     = 8;
  localparam int CA_GRP = 2;
  localparam int AW     = 3;

  localparam logic [IDX_W-1:0] IDX_T0  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_T1  = 3'd1;
  localparam logic [IDX_W-1:0] IDX_T2  = 3'd2;
  localparam logic [IDX_W-1:0] IDX_CA0 = 3'd3;
  localparam logic [IDX_W-1:0] IDX_CA1 = 3'd4;
  localparam logic [IDX_W-1:0] IDX_SER = 3'd5;

  localparam logic [AW-1:0] A_EN0  = 3'd0;
  localparam logic [AW-1:0] A_EN1  = 3'd1;
  localparam logic [AW-1:0] A_FTIM = 3'd2;
  localparam logic [AW-1:0] A_FCA0 = 3'd3;
  localparam logic [AW-1:0] A_MCA0 = 3'd5;

  localparam logic [DW-1:0] EN0_MASK  = 8'h9F;
  localparam logic [DW-1:0] EN1_MASK  = 8'h01;
  localparam logic [DW-1:0] FTIM_MASK = 8'h3F;
  localparam int            CA_OVF_BIT = 7;
endpackage

// File: rtl/intr_flag_reg.sv
module intr_flag_reg
  import intr_pkg::*;
#(
  parameter int W = DW,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_clr,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] base;

  always_comb begin
    if (wr_en) base = wdata;
    else       base = q & ~hw_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (base | hw_set) & MASK;
  end
endmodule

// File: rtl/intr_ca_group.sv
module intr_ca_group
  import intr_pkg::*;
#(
  parameter int NMOD = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flag_wr,
  input  logic            mask_wr,
  input  logic [DW-1:0]   wdata,
  input  logic [NMOD-1:0] mod_evt,
  input  logic            ovf_evt,
  input  logic            grp_en,
  output logic [DW-1:0]   flags_q,
  output logic [DW-1:0]   mask_q,
  output logic            req
);
  localparam logic [DW-1:0] MOD_BITS = DW'((1 << NMOD) - 1);
  localparam logic [DW-1:0] CA_MASK  = MOD_BITS | (DW'(1) << CA_OVF_BIT);

  logic [DW-1:0] set_b;

  always_comb begin
    set_b = '0;
    set_b[NMOD-1:0] = mod_evt;
    set_b[CA_OVF_BIT] = ovf_evt;
  end

  intr_flag_reg #(.W(DW), .MASK(CA_MASK)) u_flags (
    .clk(clk), .rst(rst), .wr_en(flag_wr), .wdata(wdata),
    .hw_clr('0), .hw_set(set_b), .q(flags_q)
  );

  intr_flag_reg #(.W(DW), .MASK(CA_MASK)) u_mask (
    .clk(clk), .rst(rst), .wr_en(mask_wr), .wdata(wdata),
    .hw_clr('0), .hw_set('0), .q(mask_q)
  );

  assign req = grp_en & (|(flags_q & mask_q));

  // R7: counter-group flags only drop through a register write
  assert_ca_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (!flag_wr && $past(!rst)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  logic          win_v;
  logic [IW-1:0] win_i;

  always_comb begin
    win_v = 1'b0;
    win_i = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        win_v = 1'b1;
        win_i = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
    end else begin
      valid_o <= win_v;
      idx_o   <= win_i;
    end
  end

  // R10: winner was requesting and no lower index was
  assert_winner_req_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ($past(req_i) >> idx_o) & N'(1));
  assert_no_lower_R10: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (($past(req_i) & ((N'(1) << idx_o) - N'(1))) == '0));
  // R11: output follows request state one cycle later
  assert_valid_lag_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && ($past(req_i) != '0)) |-> valid_o);
endmodule

// File: rtl/intr_req_ctrl.sv
module intr_req_ctrl
  import intr_pkg::*;
#(
  parameter int NMOD = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   t0_ovf_evt,
  input  logic                   t1_ovf_evt,
  input  logic                   t2_ovf_evt,
  input  logic                   t2_ext_evt,
  input  logic [CA_GRP*NMOD-1:0] ca_mod_evt,
  input  logic [CA_GRP-1:0]      ca_ovf_evt,
  input  logic                   rx_done_evt,
  input  logic                   tx_done_evt,
  input  logic                   reg_wr,
  input  logic [AW-1:0]          reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  input  logic                   ack_valid,
  input  logic [IDX_W-1:0]       ack_idx,
  output logic                   irq_valid,
  output logic [IDX_W-1:0]       irq_idx
);
  logic [DW-1:0]     en0_q, en1_q, ftim_q;
  logic [DW-1:0]     tim_set, tim_clr;
  logic [DW-1:0]     ca_f [CA_GRP];
  logic [DW-1:0]     ca_m [CA_GRP];
  logic [CA_GRP-1:0] ca_req;
  logic [CA_GRP-1:0] grp_en;
  logic [SRC_N-1:0]  req;
  logic              wr_ftim;

  assign wr_ftim = reg_wr && (reg_addr == A_FTIM);

  intr_flag_reg #(.W(DW), .MASK(EN0_MASK)) u_en0 (
    .clk(clk), .rst(rst), .wr_en(reg_wr && (reg_addr == A_EN0)),
    .wdata(reg_wdata), .hw_clr('0), .hw_set('0), .q(en0_q)
  );

  intr_flag_reg #(.W(DW), .MASK(EN1_MASK)) u_en1 (
    .clk(clk), .rst(rst), .wr_en(reg_wr && (reg_addr == A_EN1)),
    .wdata(reg_wdata), .hw_clr('0), .hw_set('0), .q(en1_q)
  );

  always_comb begin
    tim_set = {2'b00, tx_done_evt, rx_done_evt, t2_ext_evt, t2_ovf_evt,
               t1_ovf_evt, t0_ovf_evt};
    tim_clr = '0;
    tim_clr[0] = ack_valid && (ack_idx == IDX_T0);
    tim_clr[1] = ack_valid && (ack_idx == IDX_T1);
  end

  intr_flag_reg #(.W(DW), .MASK(FTIM_MASK)) u_ftim (
    .clk(clk), .rst(rst), .wr_en(wr_ftim), .wdata(reg_wdata),
    .hw_clr(tim_clr), .hw_set(tim_set), .q(ftim_q)
  );

  assign grp_en[0] = en0_q[3];
  assign grp_en[1] = en1_q[0];

  for (genvar g = 0; g < CA_GRP; g++) begin : g_ca
    intr_ca_group #(.NMOD(NMOD)) u_grp (
      .clk(clk), .rst(rst),
      .flag_wr(reg_wr && (reg_addr == AW'(A_FCA0 + g))),
      .mask_wr(reg_wr && (reg_addr == AW'(A_MCA0 + g))),
      .wdata(reg_wdata),
      .mod_evt(ca_mod_evt[g*NMOD +: NMOD]),
      .ovf_evt(ca_ovf_evt[g]),
      .grp_en(grp_en[g]),
      .flags_q(ca_f[g]), .mask_q(ca_m[g]), .req(ca_req[g])
    );
  end

  always_comb begin
    req[IDX_T0]  = en0_q[0] & ftim_q[0];
    req[IDX_T1]  = en0_q[1] & ftim_q[1];
    req[IDX_T2]  = en0_q[2] & (ftim_q[2] | ftim_q[3]);
    req[IDX_CA0] = ca_req[0];
    req[IDX_CA1] = ca_req[1];
    req[IDX_SER] = en0_q[4] & (ftim_q[4] | ftim_q[5]);
    if (!en0_q[7]) req = '0;
  end

  intr_prio_pick #(.N(SRC_N), .IW(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .req_i(req), .valid_o(irq_valid), .idx_o(irq_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        3'd0:    reg_rdata <= en0_q;
        3'd1:    reg_rdata <= en1_q;
        3'd2:    reg_rdata <= ftim_q;
        3'd3:    reg_rdata <= ca_f[0];
        3'd4:    reg_rdata <= ca_f[1];
        3'd5:    reg_rdata <= ca_m[0];
        3'd6:    reg_rdata <= ca_m[1];
        default: reg_rdata <= '0;
      endcase
    end
  end

  // R3: acknowledge of index 0 drops the timer 0 flag
  assert_t0_ack_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_idx == IDX_T0 && !t0_ovf_evt && !wr_ftim) |=> !ftim_q[0]);
  // R4: an event is never lost to a same-cycle clear
  assert_evt_wins_R4: assert property (@(posedge clk) disable iff (rst)
    t1_ovf_evt |=> ftim_q[1]);
  // R5/R8: acknowledge leaves timer 2 and serial flags alone
  assert_sticky_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !wr_ftim) |=> ((ftim_q[5:2] & $past(ftim_q[5:2])) == $past(ftim_q[5:2])));
  // R9: global bit low masks the output
  assert_glb_mask_R9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(en0_q[7]));
  // R10: index in range
  assert_idx_range_R10: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_idx <= IDX_SER));
endmodule

// File: tb/intr_req_ctrl_tb.sv
module intr_req_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NM = 4;
  localparam logic [7:0] CAM = 8'h80 | 8'((1 << NM) - 1);

  logic clk = 0, rst = 1;
  logic t0e = 0, t1e = 0, t2o = 0, t2x = 0, rxe = 0, txe = 0;
  logic [2*NM-1:0] cme = '0;
  logic [1:0] coe = '0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic ack_valid = 0;
  logic [2:0] ack_idx = '0;
  logic irq_valid;
  logic [2:0] irq_idx;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  intr_req_ctrl #(.NMOD(NM)) u_dut (
    .clk(clk), .rst(rst), .t0_ovf_evt(t0e), .t1_ovf_evt(t1e),
    .t2_ovf_evt(t2o), .t2_ext_evt(t2x), .ca_mod_evt(cme), .ca_ovf_evt(coe),
    .rx_done_evt(rxe), .tx_done_evt(txe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .irq_valid(irq_valid), .irq_idx(irq_idx)
  );

  // behavioural reference model
  logic [7:0] m_reg [8];
  logic e_v; logic [2:0] e_i; logic [7:0] e_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
      e_v = 0; e_i = 0; e_rd = 0;
    end else begin
      bit r [6];
      logic [7:0] nx;
      e_rd = m_reg[reg_addr];
      r[0] = m_reg[0][0] && m_reg[2][0];
      r[1] = m_reg[0][1] && m_reg[2][1];
      r[2] = m_reg[0][2] && (m_reg[2][2] || m_reg[2][3]);
      r[3] = m_reg[0][3] && ((m_reg[3] & m_reg[5]) != 0);
      r[4] = m_reg[1][0] && ((m_reg[4] & m_reg[6]) != 0);
      r[5] = m_reg[0][4] && (m_reg[2][4] || m_reg[2][5]);
      e_v = 0; e_i = 0;
      if (m_reg[0][7])
        for (int s = 5; s >= 0; s--) if (r[s]) begin e_v = 1; e_i = 3'(s); end
      if (reg_wr && reg_addr == 0) m_reg[0] = reg_wdata & 8'h9F;
      if (reg_wr && reg_addr == 1) m_reg[1] = reg_wdata & 8'h01;
      nx = m_reg[2];
      if (reg_wr && reg_addr == 2) nx = reg_wdata;
      else if (ack_valid && ack_idx == 0) nx[0] = 0;
      else if (ack_valid && ack_idx == 1) nx[1] = 0;
      nx = nx | {2'b00, txe, rxe, t2x, t2o, t1e, t0e};
      m_reg[2] = nx & 8'h3F;
      for (int g = 0; g < 2; g++) begin
        nx = m_reg[3+g];
        if (reg_wr && reg_addr == 3'(3+g)) nx = reg_wdata;
        nx = nx | {coe[g], 3'b000, cme[g*NM +: NM]};
        m_reg[3+g] = nx & CAM;
        if (reg_wr && reg_addr == 3'(5+g)) m_reg[5+g] = reg_wdata & CAM;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (irq_valid !== e_v || (e_v && irq_idx !== e_i)) begin
        n_bad++;
        $display("FAIL %s irq: got v=%0b idx=%0d exp v=%0b idx=%0d", cur_req,
                 irq_valid, irq_idx, e_v, e_i);
      end
      n_chk++;
      if (reg_rdata !== e_rd) begin
        n_bad++;
        $display("FAIL %s rdata: got %h exp %h", cur_req, reg_rdata, e_rd);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_in();
    t0e = 0; t1e = 0; t2o = 0; t2x = 0; rxe = 0; txe = 0; cme = '0; coe = '0;
    reg_wr = 0; ack_valid = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd_all();
    for (int a = 0; a < 8; a++) begin reg_addr = 3'(a); tick(); end
    tick();
  endtask

  task automatic ack(input logic [2:0] i);
    ack_valid = 1; ack_idx = i; tick(); ack_valid = 0;
  endtask

  initial begin
    tick(4); rst = 0;
    cur_req = "R1"; rd_all();
    cur_req = "R2";
    wr(0, 8'hFF); wr(1, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF);
    wr(3, 8'hFF); wr(4, 8'hFF); wr(2, 8'hFF); rd_all();
    wr(2, 8'h00); wr(3, 8'h00); wr(4, 8'h00); wr(0, 8'h00); tick(2); rd_all();
    cur_req = "R3";
    wr(0, 8'h83); t0e = 1; tick(); clr_in(); tick(2);
    t1e = 1; tick(); clr_in(); tick(2);
    ack(0); tick(2); ack(1); tick(2); reg_addr = 2; tick(2);
    cur_req = "R4";
    t0e = 1; ack_valid = 1; ack_idx = 0; tick(); clr_in(); tick(2);
    t0e = 1; reg_wr = 1; reg_addr = 2; reg_wdata = 8'h00; tick(); clr_in(); tick(2);
    reg_wr = 1; reg_addr = 2; reg_wdata = 8'h01; ack_valid = 1; ack_idx = 0;
    tick(); clr_in(); tick(2); wr(2, 8'h00);
    cur_req = "R5";
    wr(0, 8'h84); t2o = 1; tick(); clr_in(); tick(2); ack(2); tick(2);
    wr(2, 8'h00); t2x = 1; tick(); clr_in(); tick(2); ack(2); wr(2, 8'h00); tick(2);
    cur_req = "R6";
    wr(0, 8'h88); wr(5, 8'h01); cme[1] = 1; tick(); clr_in(); tick(2);
    wr(5, 8'h02); tick(2); wr(5, 8'h80); coe[0] = 1; tick(); clr_in(); tick(2);
    wr(5, 8'h00); tick(2); wr(3, 8'h00);
    cur_req = "R7";
    wr(0, 8'h80); wr(1, 8'h01); wr(6, 8'h8F); cme[NM+2] = 1; tick(); clr_in(); tick(2);
    ack(4); ack(3); tick(2); wr(1, 8'h00); tick(2); wr(4, 8'h00);
    cur_req = "R8";
    wr(0, 8'h90); rxe = 1; tick(); clr_in(); tick(2); ack(5); tick(2);
    wr(2, 8'h00); txe = 1; tick(); clr_in(); ack(5); tick(2); wr(2, 8'h00);
    cur_req = "R9";
    t0e = 1; t1e = 1; t2o = 1; rxe = 1; tick(); clr_in(); tick(2);
    wr(0, 8'h1F); tick(3); wr(0, 8'h9F); tick(2); wr(0, 8'h80); tick(2);
    cur_req = "R10";
    wr(0, 8'h9F); wr(1, 8'h01); wr(5, 8'h8F); wr(6, 8'h8F);
    cme = '1; coe = '1; txe = 1; tick(); clr_in(); tick(2);
    ack(0); tick(2); ack(1); tick(2); wr(2, 8'h30); tick(2);
    wr(3, 8'h00); tick(2); wr(4, 8'h00); tick(2); wr(2, 8'h00); tick(2);
    cur_req = "R11";
    wr(0, 8'h81); t0e = 1; tick(); clr_in(); ack(0); tick(3);
    cur_req = "R10";
    for (int c = 0; c < 6000; c++) begin
      logic [31:0] rv;
      rv = $urandom;
      t0e = (rv[3:0] == 0); t1e = (rv[7:4] == 0); t2o = (rv[11:8] == 0);
      t2x = (rv[15:12] == 0); rxe = (rv[19:16] == 0); txe = (rv[23:20] == 0);
      cme = (rv[26:24] == 0) ? 2*NM'($urandom) : '0;
      coe = (rv[29:27] == 0) ? 2'($urandom) : '0;
      reg_addr = 3'($urandom);
      reg_wr = ($urandom_range(0, 5) == 0);
      reg_wdata = 8'($urandom);
      ack_valid = ($urandom_range(0, 3) == 0);
      ack_idx = 3'($urandom);
      tick(); clr_in();
    end
    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1; n_chk++; n_bad++;
      $display("FAIL watchdog: got hang exp finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule